// File: doc/BRIEF.md
# Panel Configuration Serial Writer

This block is a write-only, three-line serial master used to program the configuration registers of a display panel. The three lines are an active-low chip select, a shift clock and a data line. All three rest high. A requester offers a register index and a 16-bit value through a valid/ready handshake. The block turns each accepted request into two chip-select frames of 24 bits. The first frame names the register and the second carries the value to write. When the second frame has fully closed, a single-cycle done pulse is raised.

Every frame opens with a fixed 6-bit device identifier. Two control bits follow it: a register-select bit that marks the frame as an index frame or a value frame, and a read/write bit that is always zero for writes. A single divider parameter, counted in system clocks, sets the length of each clock half-period and also the length of each guard interval around chip select. The requester must sequence any panel power-up externally.

Top module: `panel_cfg_writer`

## Requirements
- R1: After a synchronous active-high reset, the chip select, clock and data lines are all high, ready is high and done is low.
- R2: Each frame is 24 bits sent most significant bit first. Bits 23:18 hold the device ID 0x1D, bit 17 is register-select, bit 16 is read/write (0) and bits 15:0 are the payload. A bit is captured on the rising clock edge.
- R3: An accepted request produces exactly two frames. The first has register-select 0 and the index as payload. The second has register-select 1 and the value as payload.
- R4: The data line changes only while the clock is low. Each clock low phase and each clock high phase lasts DIV system clocks.
- R5: Chip select falls with clock and data high, and the first clock fall comes DIV system clocks later.
- R6: After the last high phase of a frame, chip select rises first. DIV clocks later the data line is high. DIV clocks after that the frame is over, and the second frame's chip select falls at that point.
- R7: Ready is low from the acceptance cycle until the transaction ends. A valid request offered while ready is low is ignored and does not change the frames being sent.
- R8: Done is a one-cycle pulse. It is raised with ready in the cycle after the second frame's closing interval.
- R9: Reset during a transaction abandons it. All lines return high and ready returns high on the reset edge, and neither further frames nor done follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_index | input | 16 | Register index for the first frame |
| req_value | input | 16 | Register value for the second frame |
| done | output | 1 | One-cycle pulse at transaction end |
| ser_csn | output | 1 | Chip select, active low |
| ser_sck | output | 1 | Shift clock, idles high |
| ser_sdo | output | 1 | Serial data, idles high |

## Verification
The bench targets the seams of a frame. It checks that the first clock fall trails chip select by exactly one guard interval. If the guard were dropped or doubled, the first bit would be clipped or late. It checks that chip select rises before the data line at the close, since swapping them makes the panel see a spurious last-bit change inside the frame. It offers requests while busy, which would corrupt the payload or add a third frame if ready did not gate the latch. It resets in the middle of a frame, and a design that held transaction state through reset would then raise a stray done or resume shifting.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS_GUARD,
    ST_BIT_LOW,
    ST_BIT_HIGH,
    ST_CLOSE_CS,
    ST_CLOSE_DAT
  } pcw_state_e;

endpackage

// File: rtl/pcw_divider.sv
module pcw_divider #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST);

endmodule

// File: rtl/pcw_shifter.sv
module pcw_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         cur_bit,
  output logic         next_bit,
  output logic         last
);

  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST_IDX = BW'(W - 1);

  logic [W-1:0]  sr;
  logic [BW-1:0] sent;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '1;
      sent <= '0;
    end else if (load) begin
      sr   <= load_word;
      sent <= '0;
    end else if (shift) begin
      sr   <= {sr[W-2:0], 1'b1};
      sent <= sent + 1'b1;
    end
  end

  assign cur_bit  = sr[W-1];
  assign next_bit = sr[W-2];
  assign last     = (sent == LAST_IDX);

endmodule

// File: rtl/pcw_ctrl.sv
module pcw_ctrl
  import pcw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic tick,
  input  logic sh_cur,
  input  logic sh_next,
  input  logic sh_last,
  output logic req_ready,
  output logic done,
  output logic csn,
  output logic sck,
  output logic sdo,
  output logic load,
  output logic load_second,
  output logic shift,
  output logic div_restart
);

  pcw_state_e state;
  logic       second;

  assign load_second = (state != ST_IDLE);
  assign load        = (state == ST_IDLE && req_valid && req_ready) ||
                       (state == ST_CLOSE_DAT && tick && !second);
  assign shift       = (state == ST_BIT_HIGH) && tick && !sh_last;
  assign div_restart = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      second    <= 1'b0;
      req_ready <= 1'b1;
      done      <= 1'b0;
      csn       <= 1'b1;
      sck       <= 1'b1;
      sdo       <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            state     <= ST_CS_GUARD;
            second    <= 1'b0;
            req_ready <= 1'b0;
            csn       <= 1'b0;
          end
        end
        ST_CS_GUARD: begin
          if (tick) begin
            state <= ST_BIT_LOW;
            sck   <= 1'b0;
            sdo   <= sh_cur;
          end
        end
        ST_BIT_LOW: begin
          if (tick) begin
            state <= ST_BIT_HIGH;
            sck   <= 1'b1;
          end
        end
        ST_BIT_HIGH: begin
          if (tick) begin
            if (sh_last) begin
              state <= ST_CLOSE_CS;
              csn   <= 1'b1;
            end else begin
              state <= ST_BIT_LOW;
              sck   <= 1'b0;
              sdo   <= sh_next;
            end
          end
        end
        ST_CLOSE_CS: begin
          if (tick) begin
            state <= ST_CLOSE_DAT;
            sdo   <= 1'b1;
          end
        end
        ST_CLOSE_DAT: begin
          if (tick) begin
            if (!second) begin
              state  <= ST_CS_GUARD;
              second <= 1'b1;
              csn    <= 1'b0;
            end else begin
              state     <= ST_IDLE;
              req_ready <= 1'b1;
              done      <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/panel_cfg_writer.sv
module panel_cfg_writer #(
  parameter int          DIV    = 4,
  parameter int          ID_W   = 6,
  parameter int          PAY_W  = 16,
  parameter logic [5:0]  DEV_ID = 6'h1D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PAY_W-1:0] req_index,
  input  logic [PAY_W-1:0] req_value,
  output logic             done,
  output logic             ser_csn,
  output logic             ser_sck,
  output logic             ser_sdo
);

  localparam int FRAME_W = ID_W + 2 + PAY_W;
  localparam logic [ID_W-1:0] ID_BITS = ID_W'(DEV_ID);

  logic             tick, load, load_second, shift, div_restart;
  logic             sh_cur, sh_next, sh_last;
  logic [PAY_W-1:0] value_q;
  logic [FRAME_W-1:0] frame_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
    end else if (req_valid && req_ready) begin
      value_q <= req_value;
    end
  end

  // register-select = 0 with index, then 1 with value; read/write always 0
  assign frame_word = load_second ? {ID_BITS, 1'b1, 1'b0, value_q}
                                  : {ID_BITS, 1'b0, 1'b0, req_index};

  pcw_divider #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (div_restart),
    .tick    (tick)
  );

  pcw_shifter #(.W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_word (frame_word),
    .shift     (shift),
    .cur_bit   (sh_cur),
    .next_bit  (sh_next),
    .last      (sh_last)
  );

  pcw_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .tick        (tick),
    .sh_cur      (sh_cur),
    .sh_next     (sh_next),
    .sh_last     (sh_last),
    .req_ready   (req_ready),
    .done        (done),
    .csn         (ser_csn),
    .sck         (ser_sck),
    .sdo         (ser_sdo),
    .load        (load),
    .load_second (load_second),
    .shift       (shift),
    .div_restart (div_restart)
  );

endmodule

// File: rtl/pcw_checker.sv
module pcw_checker #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic done,
  input logic ser_csn,
  input logic ser_sck,
  input logic ser_sdo
);

  logic [31:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (!ser_sck) low_cnt <= low_cnt + 1;
    else low_cnt <= '0;
  end

  a_r1_idle_lines_high: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ser_csn && ser_sck && ser_sdo));

  a_r4_sdo_stable_clk_high: assert property (@(posedge clk) disable iff (rst)
    (ser_sck && $past(ser_sck) && !ser_csn) |-> $stable(ser_sdo));

  a_r4_low_phase_len: assert property (@(posedge clk) disable iff (rst)
    (!ser_csn && $rose(ser_sck)) |-> (low_cnt == 32'(DIV)));

  a_r6_clk_high_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_csn) |-> ser_sck);

  a_r5_clk_toggles_inside_cs: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_sck) |-> !ser_csn);

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !ser_csn |-> !req_ready);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_with_ready: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

endmodule

bind panel_cfg_writer pcw_checker #(.DIV(DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done      (done),
  .ser_csn   (ser_csn),
  .ser_sck   (ser_sck),
  .ser_sdo   (ser_sdo)
);

// File: tb/tb_panel_cfg_writer.sv
`timescale 1ns/1ps
module tb_panel_cfg_writer;

  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready, done, ser_csn, ser_sck, ser_sdo;
  logic [15:0] req_index = '0;
  logic [15:0] req_value = '0;

  always #2.5 clk = ~clk;

  panel_cfg_writer #(.DIV(DIV)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_value(req_value), .done(done),
    .ser_csn(ser_csn), .ser_sck(ser_sck), .ser_sdo(ser_sdo)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  // monitor state
  int nfr = 0;
  int nbits = 0;
  int nfall = 0;
  int done_cnt = 0;
  int last_rise = 0;
  logic [23:0] sh = '0;
  logic [23:0] fr [4];
  int bitcnt [4];
  int t_csf [4];
  int t_csr [4];
  int t_lr [4];
  int t_sdo [4];
  int t_f1 [4];
  int t_r1 [4];
  int t_f2 [4];

  localparam logic [31:0] VEC [6] = '{
    {16'h0009, 16'h4000}, {16'h000A, 16'h2000}, {16'h0001, 16'h409D},
    {16'hFFFF, 16'h0000}, {16'h0000, 16'hFFFF}, {16'h5AA5, 16'hA55A}
  };

  always @(posedge clk) cyc = cyc + 1;
  always @(negedge clk) if (done) done_cnt = done_cnt + 1;

  always @(negedge ser_csn) if (nfr < 4) begin
    t_csf[nfr] = cyc; nbits = 0; nfall = 0; sh = '0;
  end
  always @(negedge ser_sck) if (!ser_csn && nfr < 4) begin
    if (nfall == 0) t_f1[nfr] = cyc;
    if (nfall == 1) t_f2[nfr] = cyc;
    nfall = nfall + 1;
  end
  always @(posedge ser_sck) if (!ser_csn && nfr < 4) begin
    sh = {sh[22:0], ser_sdo};
    if (nbits == 0) t_r1[nfr] = cyc;
    nbits = nbits + 1;
    last_rise = cyc;
  end
  always @(posedge ser_csn) if (nfr < 4) begin
    fr[nfr] = sh; bitcnt[nfr] = nbits; t_csr[nfr] = cyc; t_lr[nfr] = last_rise;
    nfr = nfr + 1;
  end
  always @(posedge ser_sdo) if (ser_csn && nfr > 0 && nfr <= 4) t_sdo[nfr-1] = cyc;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    nfr = 0; done_cnt = 0;
  endtask

  task automatic start_write(input logic [15:0] idx, input logic [15:0] val);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_index = idx; req_value = val; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_index = '0; req_value = '0;
  endtask

  task automatic wait_done(input int base);
    for (int i = 0; i < 2000 && done_cnt == base; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ser_csn == 1, "R1", "csn", ser_csn, 1);
    check(ser_sck == 1, "R1", "sck", ser_sck, 1);
    check(ser_sdo == 1, "R1", "sdo", ser_sdo, 1);
    check(req_ready == 1, "R1", "ready", req_ready, 1);
    check(done == 0, "R1", "done", done, 0);

    // R2/R3 vector walk
    for (int v = 0; v < 6; v++) begin
      logic [15:0] idx, val;
      idx = VEC[v][31:16]; val = VEC[v][15:0];
      clear_mon();
      start_write(idx, val);
      check(req_ready == 0, "R7", "ready low while busy", req_ready, 0);
      wait_done(0);
      @(negedge clk);
      check(nfr == 2, "R3", "frame count", nfr, 2);
      check(fr[0] == {6'h1D, 2'b00, idx} && bitcnt[0] == 24, "R2",
            "index frame", fr[0], {6'h1D, 2'b00, idx});
      check(fr[1] == {6'h1D, 2'b10, val} && bitcnt[1] == 24, "R3",
            "value frame", fr[1], {6'h1D, 2'b10, val});
      check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
      if (v == 0) begin
        // timing on first transaction (index 0x0009 ends in 1, value ends in 0)
        check(t_f1[0] - t_csf[0] == DIV, "R5", "cs to first clk fall",
              t_f1[0] - t_csf[0], DIV);
        check(t_r1[0] - t_f1[0] == DIV, "R4", "clk low width",
              t_r1[0] - t_f1[0], DIV);
        check(t_f2[0] - t_r1[0] == DIV, "R4", "clk high width",
              t_f2[0] - t_r1[0], DIV);
        check(t_csr[1] - t_lr[1] == DIV, "R6", "last rise to cs rise",
              t_csr[1] - t_lr[1], DIV);
        check(t_sdo[1] - t_csr[1] == DIV, "R6", "cs rise to sdo rise",
              t_sdo[1] - t_csr[1], DIV);
        check(t_csf[1] - t_csr[0] == 2 * DIV, "R6", "gap between frames",
              t_csf[1] - t_csr[0], 2 * DIV);
      end
    end

    // R8 done width and ready together
    clear_mon();
    start_write(16'h0012, 16'h0034);
    while (!done) @(negedge clk);
    check(req_ready == 1, "R8", "ready with done", req_ready, 1);
    @(negedge clk);
    check(done == 0, "R8", "done one cycle", done, 0);

    // R7 requests while busy are ignored
    clear_mon();
    start_write(16'h00C3, 16'h1234);
    repeat (20) @(negedge clk);
    req_index = 16'hBEEF; req_value = 16'hDEAD; req_valid = 1'b1;
    repeat (10) @(negedge clk);
    req_valid = 1'b0;
    wait_done(0);
    repeat (400) @(negedge clk);
    check(nfr == 2, "R7", "no extra frame", nfr, 2);
    check(fr[0] == {6'h1D, 2'b00, 16'h00C3}, "R7", "index intact",
          fr[0], {6'h1D, 2'b00, 16'h00C3});
    check(fr[1] == {6'h1D, 2'b10, 16'h1234}, "R7", "value intact",
          fr[1], {6'h1D, 2'b10, 16'h1234});

    // R9 reset mid-transaction
    clear_mon();
    start_write(16'h0F0F, 16'h0000);
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(ser_csn && ser_sck && ser_sdo, "R9", "lines high after reset",
          {ser_csn, ser_sck, ser_sdo}, 3'b111);
    check(req_ready == 1, "R9", "ready after reset", req_ready, 1);
    clear_mon();
    repeat (400) @(negedge clk);
    check(nfr == 0, "R9", "no frame after abort", nfr, 0);
    check(done_cnt == 0, "R9", "no done after abort", done_cnt, 0);
    start_write(16'h0007, 16'h0021);
    wait_done(0);
    @(negedge clk);
    check(fr[1] == {6'h1D, 2'b10, 16'h0021}, "R9", "clean write after abort",
          fr[1], {6'h1D, 2'b10, 16'h0021});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule